// File: doc/BRIEF.md
# Supply-Loss Write Guard

This block stands between a host and a byte-wide nonvolatile memory and decides, cycle by cycle, whether the host's active-low chip-select, write strobe and output-enable reach the memory. It watches two digitised supply flags from an external comparator. The first says the supply sits above the deselect threshold. The second says it still sits above the lowest edge of the threshold band. While the supply is out of range, no write strobe and no output drive leave the block. Stored data is never touched by the guard itself.

Both flags pass through a two-stage synchroniser. When the upper flag drops, the guard keeps passing the host for a short protect window, `PROTECT_CYC` cycles, and then locks. If the lower flag also drops during that window, the supply has fallen quickly. The window then starts again from the moment of that second drop. Leaving the lock needs both flags high for a much longer recovery window, `RECOVER_CYC` cycles. Any dip during recovery restarts the wait from the beginning. After reset the guard is locked and must serve the full recovery window.

Top module: `pwr_guard`

## Requirements
- R1: While reset is asserted and after it is released, the guard is locked. `inputs_ok_o` is 0 and all three qualified outputs are 1 until a complete recovery window has elapsed.
- R2: While locked or recovering, `ce_q_n_o`, `we_q_n_o` and `oe_q_n_o` stay at 1, whatever the host drives on `ce_n_i`, `we_n_i` and `oe_n_i`.
- R3: If `pg_i` and `floor_ok_i` are both 1 when sampled at clock edge k and stay 1, `inputs_ok_o` rises at edge k+2+RECOVER_CYC.
- R4: If either flag is sampled 0 during recovery, the guard returns to the locked state. The next recovery then takes the full RECOVER_CYC window again.
- R5: If `pg_i` is sampled 0 at edge k while the guard passes the host and stays 0, with `floor_ok_i` held 1, the host keeps passing until the guard locks at edge k+2+PROTECT_CYC.
- R6: If `floor_ok_i` is first sampled 0 at edge j during the protect window, the window restarts. The guard then locks at edge j+2+PROTECT_CYC.
- R7: If `pg_i` is sampled 1 again before the protect window expires, the guard returns to passing the host without locking.
- R8: A write strobe held low by the host when the guard locks is cut off. `we_q_n_o` goes to 1 in the same cycle in which `inputs_ok_o` falls.
- R9: While passing, `ce_q_n_o` equals `ce_n_i`. `we_q_n_o` is 0 only when `ce_n_i` and `we_n_i` are both 0. `oe_q_n_o` is 0 only when `ce_n_i` and `oe_n_i` are 0 and `we_n_i` is 1, so output drive is never enabled during a write.
- R10: `inputs_ok_o` is 1 exactly while the guard passes the host, that is, in normal running or inside the protect window. `we_q_n_o` is never 0 while `inputs_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_i | input | 1 | Supply above deselect threshold (asynchronous) |
| floor_ok_i | input | 1 | Supply above lowest edge of the threshold band (asynchronous) |
| ce_n_i | input | 1 | Host chip-select, active low |
| we_n_i | input | 1 | Host write strobe, active low |
| oe_n_i | input | 1 | Host output-enable, active low |
| ce_q_n_o | output | 1 | Qualified chip-select to memory, active low |
| we_q_n_o | output | 1 | Qualified write strobe to memory, active low |
| oe_q_n_o | output | 1 | Qualified output-enable to memory, active low |
| inputs_ok_o | output | 1 | High while host inputs are recognised |

## Verification
The bench targets the exact edge on which each window closes. An off-by-one counter would let the host through one cycle early after recovery, or one cycle too long after the supply drops. A flag dip in the middle of recovery is applied, and so is a short glitch that lasts a single cycle. A guard that only paused its count would then recover early. Fast falls, where the lower flag drops some cycles after the upper one, check that the window restarts and does not simply continue. A write strobe held low across the lock moment checks that the write is cut off. Read and write patterns that overlap check that output drive stays off during a write.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
   typedef enum logic [1:0] {
      GS_LOCK = 2'd0,
      GS_WAKE = 2'd1,
      GS_RUN  = 2'd2,
      GS_FALL = 2'd3
   } guard_st_t;
endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= '0;
               else        stg[gi] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= '0;
               else        stg[gi] <= stg[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
   import pwr_guard_pkg::*;
#(
   parameter int PROTECT_CYC = 1000,
   parameter int RECOVER_CYC = 25000,
   localparam int MAXC = (PROTECT_CYC > RECOVER_CYC) ? PROTECT_CYC : RECOVER_CYC,
   localparam int CW   = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pg_s,
   input  logic floor_s,
   output logic pass_o
);
   guard_st_t      st_q;
   logic [CW-1:0]  cnt_q;
   logic           floor_d;
   logic           floor_drop;
   logic           both_up;

   assign floor_drop = floor_d & ~floor_s;
   assign both_up    = pg_s & floor_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) floor_d <= 1'b0;
      else        floor_d <= floor_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= GS_LOCK;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            GS_LOCK: begin
               if (both_up) begin
                  st_q  <= GS_WAKE;
                  cnt_q <= CW'(RECOVER_CYC - 1);
               end
            end
            GS_WAKE: begin
               if (!both_up)          st_q  <= GS_LOCK;
               else if (cnt_q == '0)  st_q  <= GS_RUN;
               else                   cnt_q <= cnt_q - 1'b1;
            end
            GS_RUN: begin
               if (!pg_s) begin
                  st_q  <= GS_FALL;
                  cnt_q <= CW'(PROTECT_CYC - 1);
               end
            end
            GS_FALL: begin
               if (pg_s)              st_q  <= GS_RUN;
               else if (floor_drop)   cnt_q <= CW'(PROTECT_CYC - 1);
               else if (cnt_q == '0)  st_q  <= GS_LOCK;
               else                   cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= GS_LOCK;
         endcase
      end
   end

   assign pass_o = (st_q == GS_RUN) || (st_q == GS_FALL);
endmodule

// File: rtl/pwr_guard_gate.sv
module pwr_guard_gate (
   input  logic pass_i,
   input  logic ce_n_i,
   input  logic we_n_i,
   input  logic oe_n_i,
   output logic ce_q_n_o,
   output logic we_q_n_o,
   output logic oe_q_n_o
);
   logic wr_req;
   logic rd_req;

   assign wr_req = ~ce_n_i & ~we_n_i;
   assign rd_req = ~ce_n_i & ~oe_n_i & we_n_i;

   always_comb begin
      ce_q_n_o = 1'b1;
      we_q_n_o = 1'b1;
      oe_q_n_o = 1'b1;
      if (pass_i) begin
         ce_q_n_o = ce_n_i;
         we_q_n_o = ~wr_req;
         oe_q_n_o = ~rd_req;
      end
   end
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard #(
   parameter int PROTECT_CYC = 1000,
   parameter int RECOVER_CYC = 25000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pg_i,
   input  logic floor_ok_i,
   input  logic ce_n_i,
   input  logic we_n_i,
   input  logic oe_n_i,
   output logic ce_q_n_o,
   output logic we_q_n_o,
   output logic oe_q_n_o,
   output logic inputs_ok_o
);
   generate
      if (PROTECT_CYC < 1) begin : g_bad_protect
         $error("PROTECT_CYC must be at least 1");
      end
      if (RECOVER_CYC < 1) begin : g_bad_recover
         $error("RECOVER_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0] flags_s;
   logic       pass;

   pwr_guard_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({floor_ok_i, pg_i}),
      .q_o   (flags_s)
   );

   pwr_guard_seq #(.PROTECT_CYC(PROTECT_CYC), .RECOVER_CYC(RECOVER_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pg_s    (flags_s[0]),
      .floor_s (flags_s[1]),
      .pass_o  (pass)
   );

   pwr_guard_gate u_gate (
      .pass_i   (pass),
      .ce_n_i   (ce_n_i),
      .we_n_i   (we_n_i),
      .oe_n_i   (oe_n_i),
      .ce_q_n_o (ce_q_n_o),
      .we_q_n_o (we_q_n_o),
      .oe_q_n_o (oe_q_n_o)
   );

   assign inputs_ok_o = pass;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
   parameter int PROTECT_CYC = 1000,
   parameter int RECOVER_CYC = 25000
) (
   input logic clk,
   input logic rst_n,
   input logic pg_i,
   input logic floor_ok_i,
   input logic ce_n_i,
   input logic we_n_i,
   input logic oe_n_i,
   input logic ce_q_n_o,
   input logic we_q_n_o,
   input logic oe_q_n_o,
   input logic inputs_ok_o
);
   int unsigned hi_cnt;
   int unsigned lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= 0;
         lo_cnt <= 0;
      end else begin
         if (pg_i && floor_ok_i) hi_cnt <= (hi_cnt < 32'h7fff_ffff) ? hi_cnt + 1 : hi_cnt;
         else                    hi_cnt <= 0;
         if (!pg_i && !floor_ok_i) lo_cnt <= (lo_cnt < 32'h7fff_ffff) ? lo_cnt + 1 : lo_cnt;
         else                      lo_cnt <= 0;
      end
   end

   // R2 R10: nothing reaches the memory while host inputs are not recognised
   a_r2_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !inputs_ok_o |-> (ce_q_n_o && we_q_n_o && oe_q_n_o));

   // R3 R4: recognition only after an unbroken good-supply stretch
   a_r3_recover_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inputs_ok_o) |-> (hi_cnt >= RECOVER_CYC));

   // R5 R6: a sustained collapse always ends in the locked state
   a_r6_lock_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_cnt >= PROTECT_CYC + 4) |-> !inputs_ok_o);

   // R8: a held strobe is released as soon as recognition ends
   a_r8_write_cut: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inputs_ok_o) |-> we_q_n_o);

   // R9: a passed write strobe never coincides with output drive
   a_r9_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we_q_n_o |-> oe_q_n_o);

   // R9: a host write is forwarded while recognised
   a_r9_write_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (inputs_ok_o && !ce_n_i && !we_n_i) |-> !we_q_n_o);

   // R9: a deselected host never drives the memory
   a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n_i |-> (we_q_n_o && oe_q_n_o && ce_q_n_o));
endmodule

bind pwr_guard pwr_guard_chk #(
   .PROTECT_CYC(PROTECT_CYC),
   .RECOVER_CYC(RECOVER_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pg_i        (pg_i),
   .floor_ok_i  (floor_ok_i),
   .ce_n_i      (ce_n_i),
   .we_n_i      (we_n_i),
   .oe_n_i      (oe_n_i),
   .ce_q_n_o    (ce_q_n_o),
   .we_q_n_o    (we_q_n_o),
   .oe_q_n_o    (oe_q_n_o),
   .inputs_ok_o (inputs_ok_o)
);

// File: tb/tb_pwr_guard.sv
module tb_pwr_guard;
   localparam int CLK_PERIOD = 10;
   localparam int P = 4;
   localparam int R = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pg_i = 1'b0, floor_ok_i = 1'b0;
   logic ce_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b1;
   logic ce_q_n_o, we_q_n_o, oe_q_n_o, inputs_ok_o;

   int vectors = 0;
   int miscompares = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_guard #(.PROTECT_CYC(P), .RECOVER_CYC(R)) dut (
      .clk(clk), .rst_n(rst_n), .pg_i(pg_i), .floor_ok_i(floor_ok_i),
      .ce_n_i(ce_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i),
      .ce_q_n_o(ce_q_n_o), .we_q_n_o(we_q_n_o), .oe_q_n_o(oe_q_n_o),
      .inputs_ok_o(inputs_ok_o)
   );

   // Behavioural reference: pipelines of sampled flags, a mode and a remaining-cycle count
   bit pg_q[$];
   bit fl_q[$];
   bit fl_prev;
   int mode;      // 0 locked, 1 recovering, 2 running, 3 protect window
   int remain;

   initial begin
      pg_q = '{0, 0};
      fl_q = '{0, 0};
      fl_prev = 0;
      mode = 0;
      remain = 0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q = '{0, 0};
         fl_q = '{0, 0};
         fl_prev = 0;
         mode = 0;
         remain = 0;
      end else begin
         bit pgs, fls;
         pgs = pg_q[1];
         fls = fl_q[1];
         case (mode)
            0: if (pgs && fls) begin mode = 1; remain = R; end
            1: if (!(pgs && fls)) mode = 0;
               else begin remain--; if (remain == 0) mode = 2; end
            2: if (!pgs) begin mode = 3; remain = P; end
            default: if (pgs) mode = 2;
               else if (fl_prev && !fls) remain = P;
               else begin remain--; if (remain == 0) mode = 0; end
         endcase
         fl_prev = fls;
         void'(pg_q.pop_back());
         void'(fl_q.pop_back());
         pg_q.push_front(pg_i);
         fl_q.push_front(floor_ok_i);
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         bit pass;
         logic e_ce, e_we, e_oe;
         pass = (mode >= 2);
         e_ce = pass ? ce_n_i : 1'b1;
         e_we = pass ? (ce_n_i | we_n_i) : 1'b1;
         e_oe = pass ? (ce_n_i | oe_n_i | ~we_n_i) : 1'b1;
         chk(cur_req, "inputs_ok_o", inputs_ok_o, pass);
         chk(pass ? "R9" : "R2", "ce_q_n_o", ce_q_n_o, e_ce);
         chk(pass ? "R9" : "R2", "we_q_n_o", we_q_n_o, e_we);
         chk(pass ? "R9" : "R2", "oe_q_n_o", oe_q_n_o, e_oe);
         if (!inputs_ok_o && we_q_n_o !== 1'b1) begin
            miscompares++;
            $display("FAIL R10 write strobe outside normal state actual=%b expected=1", we_q_n_o);
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic rnd_bus();
      {ce_n_i, we_n_i, oe_n_i} = 3'($urandom);
   endtask

   task automatic rnd_cyc(int n);
      repeat (n) begin rnd_bus(); cyc(1); end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      // R1: reset state, raw strobes active
      cur_req = "R1";
      ce_n_i = 0; we_n_i = 0; oe_n_i = 0;
      cyc(3);
      rst_n = 1'b1;
      rnd_cyc(6);

      // R2: supply good only partially: still locked, inputs ignored
      cur_req = "R2";
      pg_i = 1; floor_ok_i = 0;
      rnd_cyc(8);

      // R3: full recovery window, then traffic
      cur_req = "R3";
      floor_ok_i = 1;
      rnd_cyc(R + 6);

      // R9: directed bus patterns while running
      cur_req = "R9";
      for (int i = 0; i < 8; i++) begin
         {ce_n_i, we_n_i, oe_n_i} = 3'(i);
         cyc(1);
      end
      rnd_cyc(20);

      // R5: slow fall, write held low across the lock edge (R8)
      cur_req = "R5";
      ce_n_i = 0; we_n_i = 0; oe_n_i = 1;
      pg_i = 0;
      cyc(P + 5);
      cur_req = "R8";
      cyc(3);

      // R4: dip in the middle of recovery, then a one-cycle glitch
      cur_req = "R4";
      pg_i = 1;
      rnd_cyc(R / 2);
      pg_i = 0;
      cyc(1);
      pg_i = 1;
      rnd_cyc(R - 3);
      floor_ok_i = 0;
      cyc(1);
      floor_ok_i = 1;
      rnd_cyc(R + 6);

      // R7: supply returns inside the protect window
      cur_req = "R7";
      pg_i = 0;
      rnd_cyc(P);
      pg_i = 1;
      rnd_cyc(10);

      // R6: fast fall, floor drops a few cycles after the upper flag
      cur_req = "R6";
      ce_n_i = 0; we_n_i = 0;
      pg_i = 0;
      cyc(P - 1);
      floor_ok_i = 0;
      cyc(P + 6);

      // R6: both flags drop together
      pg_i = 1; floor_ok_i = 1;
      rnd_cyc(R + 5);
      pg_i = 0; floor_ok_i = 0;
      rnd_cyc(P + 6);

      // R10: random supply activity
      cur_req = "R10";
      for (int k = 0; k < 400; k++) begin
         if (($urandom % 16) == 0) pg_i = ~pg_i;
         if (($urandom % 24) == 0) floor_ok_i = ~floor_ok_i;
         rnd_bus();
         cyc(1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule